// File: doc/BRIEF.md
# Status Register Write-Protect Guard

This block keeps the protection fields of a serial memory's status register. These fields are a lock-down bit and a two-bit protected-range code. On each write-status request the block decides whether that request may change them. The command decoder sends a completion strobe when chip-select rises. With the strobe it sends the number of data bits it received and the data byte. The block samples the external write-protect pin (active low) in that same cycle.

The lock-down bit has an effect only while the write-protect pin is low. With the pin low and the lock set, the block refuses the write and raises a one-cycle reject pulse. In every other case it applies the write and raises a one-cycle accept pulse. A read request returns the status byte one cycle later. Separately, the block tells the array-write path whether an address falls in the range that the range code protects.

Top module: `sr_lock_guard`

## Requirements
- R1: After a synchronous active-low reset, `status_byte` reads 0x00 and `arr_allow` is 1 for every address.
- R2: The status byte holds the lock bit at bit 7 and the range code at bits 3:2. Every other bit always reads 0, even when a write carries ones there.
- R3: A complete write (`wr_done` with `wr_bits` equal to 8) while `wp_n` is 1 executes whatever the lock bit holds. The next cycle the register holds `wr_data & 0x8C` and `wr_accept` is 1 for one cycle.
- R4: A complete write while `wp_n` is 0 and the lock bit is 0 executes, with the same update and accept pulse as R3.
- R5: A complete write while `wp_n` is 0 and the lock bit is 1 is refused. The register keeps its value and `wr_reject` is 1 for one cycle.
- R6: `wp_n` matters only in the cycle in which `wr_done` is high. Its value in any other cycle has no effect on the decision.
- R7: A `wr_done` with `wr_bits` other than 8 changes nothing and raises neither `wr_accept` nor `wr_reject`.
- R8: A `rd_req` gives `rd_valid` = 1 the next cycle, with `rd_byte` equal to the status byte as it stood in the request cycle.
- R9: `arr_allow` follows the range code as follows. With code 0, every address is allowed. With code 1, addresses whose two top bits are both 1 are blocked. With code 2, addresses whose top bit is 1 are blocked. With code 3, every address is blocked.
- R10: `wr_accept` and `wr_reject` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| wr_done | input | 1 | Write-status command finished (chip-select rose) |
| wr_bits | input | 4 | Number of data bits received for that command |
| wr_data | input | 8 | Data byte of the write-status command |
| rd_req | input | 1 | Status read request |
| arr_addr | input | ADDR_W | Address of a pending array write |
| status_byte | output | 8 | Current status byte |
| wr_accept | output | 1 | One-cycle pulse: write executed |
| wr_reject | output | 1 | One-cycle pulse: write refused by lock-down |
| rd_valid | output | 1 | Read answer valid |
| rd_byte | output | 8 | Status byte returned for a read |
| arr_allow | output | 1 | Array write to `arr_addr` permitted |

## Verification
The bench sets the lock and then drops `wp_n`. A design that ignores the pin would accept a write that must be refused, or would refuse one taken with the pin high. The bench toggles `wp_n` only in cycles without `wr_done`, which exposes a design that latches the pin early or late. It sends short and long bit counts, which catch a design that updates on a partial byte. It writes 0xFF, so undefined bits that are stored show up on readback. It reads in the same cycle as a write, which shows whether the read returns the old value. It sweeps addresses over all four range codes to catch a swapped quarter/half boundary.

// File: rtl/sr_guard_pkg.sv
// Shared constants and types for the status-register write-protect guard.
// Assumes an 8-bit status register with fixed protection field positions.
package sr_guard_pkg;
    localparam int SR_W     = 8;
    localparam int CNT_W    = 4;
    localparam int LOCK_POS = 7;
    localparam int RNG_HI   = 3;
    localparam int RNG_LO   = 2;
    localparam logic [SR_W-1:0] SR_KEEP = (SR_W'(1) << LOCK_POS)
                                        | (SR_W'(1) << RNG_HI)
                                        | (SR_W'(1) << RNG_LO);
    localparam logic [CNT_W-1:0] FULL_BITS = CNT_W'(SR_W);

    typedef enum logic [1:0] {
        RNG_NONE = 2'd0,
        RNG_QTR  = 2'd1,
        RNG_HALF = 2'd2,
        RNG_ALL  = 2'd3
    } rng_e;
endpackage

// File: rtl/sr_lock_decide.sv
// Decides whether a completed write-status command executes or is refused.
// Assumes wr_done is a single-cycle strobe; wp_n is sampled in that cycle.
module sr_lock_decide
    import sr_guard_pkg::*;
(
    input  logic             wp_n,
    input  logic             lock,
    input  logic             wr_done,
    input  logic [CNT_W-1:0] wr_bits,
    output logic             do_write,
    output logic             do_reject
);
    logic full_byte;
    logic locked;

    // Lock-down applies only when the pin is low and the lock bit is set.
    always_comb begin
        full_byte = (wr_bits == FULL_BITS);
        locked    = lock && !wp_n;
        do_write  = wr_done && full_byte && !locked;
        do_reject = wr_done && full_byte && locked;
    end
endmodule

// File: rtl/sr_prot_reg.sv
// Storage for the protection fields; undefined bits are masked to zero.
// Assumes do_write is already qualified by the lock-down decision.
module sr_prot_reg
    import sr_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            do_write,
    input  logic [SR_W-1:0] wr_data,
    output logic [SR_W-1:0] sr_q
);
    // Load masked data on an approved write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (do_write)
            sr_q <= wr_data & SR_KEEP;
    end
endmodule

// File: rtl/sr_range_check.sv
// Maps the range code to a permit flag for an array write address.
// Assumes ADDR_W >= 2; protected ranges sit at the top of the array.
module sr_range_check
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  rng_e              rng,
    input  logic [ADDR_W-1:0] addr,
    output logic              allow
);
    logic top1;
    logic top2;

    // Pick the two address bits that bound the quarter and half ranges.
    always_comb begin
        top1 = addr[ADDR_W-1];
        top2 = addr[ADDR_W-1] && addr[ADDR_W-2];
    end

    // Permit unless the address lands in the coded protected range.
    always_comb begin
        case (rng)
            RNG_NONE: allow = 1'b1;
            RNG_QTR:  allow = !top2;
            RNG_HALF: allow = !top1;
            default:  allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/sr_lock_guard.sv
// Top of the write-protect guard: lock-down decision, field storage,
// status readback and protected-range permit. Assumes the command decoder
// delivers one wr_done strobe per write-status command, with its bit count.
module sr_lock_guard
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wr_done,
    input  logic [CNT_W-1:0]  wr_bits,
    input  logic [SR_W-1:0]   wr_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [SR_W-1:0]   status_byte,
    output logic              wr_accept,
    output logic              wr_reject,
    output logic              rd_valid,
    output logic [SR_W-1:0]   rd_byte,
    output logic              arr_allow
);
    logic do_write;
    logic do_reject;
    logic [SR_W-1:0] sr_q;
    rng_e rng;

    sr_lock_decide u_decide (
        .wp_n      (wp_n),
        .lock      (sr_q[LOCK_POS]),
        .wr_done   (wr_done),
        .wr_bits   (wr_bits),
        .do_write  (do_write),
        .do_reject (do_reject)
    );

    sr_prot_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_write (do_write),
        .wr_data  (wr_data),
        .sr_q     (sr_q)
    );

    // Extract the range code from the stored status bits.
    always_comb rng = rng_e'(sr_q[RNG_HI:RNG_LO]);

    sr_range_check #(.ADDR_W(ADDR_W)) u_range (
        .rng   (rng),
        .addr  (arr_addr),
        .allow (arr_allow)
    );

    // Drive the live status byte straight from storage.
    always_comb status_byte = sr_q;

    // Register the decision pulses and the read answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_accept <= 1'b0;
            wr_reject <= 1'b0;
            rd_valid  <= 1'b0;
            rd_byte   <= '0;
        end else begin
            wr_accept <= do_write;
            wr_reject <= do_reject;
            rd_valid  <= rd_req;
            if (rd_req)
                rd_byte <= sr_q;
        end
    end
endmodule

// File: rtl/sr_lock_guard_chk.sv
// Property checker for sr_lock_guard, attached with bind below.
module sr_lock_guard_chk
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic              wr_done,
    input logic [CNT_W-1:0]  wr_bits,
    input logic [SR_W-1:0]   wr_data,
    input logic              rd_req,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [SR_W-1:0]   status_byte,
    input logic              wr_accept,
    input logic              wr_reject,
    input logic              rd_valid,
    input logic [SR_W-1:0]   rd_byte,
    input logic              arr_allow
);
    assert_undef_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte & ~SR_KEEP) == '0);

    assert_wp_high_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wr_bits == FULL_BITS && wp_n)
        |=> (wr_accept && status_byte == ($past(wr_data) & SR_KEEP)));

    assert_unlocked_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wr_bits == FULL_BITS && !wp_n && !status_byte[LOCK_POS])
        |=> wr_accept);

    assert_locked_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wr_bits == FULL_BITS && !wp_n && status_byte[LOCK_POS])
        |=> (wr_reject && $stable(status_byte)));

    assert_partial_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wr_bits != FULL_BITS)
        |=> (!wr_accept && !wr_reject && $stable(status_byte)));

    assert_read_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_valid && rd_byte == $past(status_byte)));

    assert_all_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[RNG_HI:RNG_LO] == 2'b11) |-> !arr_allow);

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_accept && wr_reject));
endmodule

bind sr_lock_guard sr_lock_guard_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/sr_lock_guard_tb_top.sv
// Bench: behavioural reference model compared against the design each cycle.
module sr_lock_guard_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic          wr_done = 1'b0;
    logic [3:0]    wr_bits = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [7:0]    status_byte;
    logic          wr_accept;
    logic          wr_reject;
    logic          rd_valid;
    logic [7:0]    rd_byte;
    logic          arr_allow;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit finished = 0;

    // Reference model state.
    bit       m_lock = 0;
    bit [1:0] m_rng = 0;
    bit       e_acc = 0;
    bit       e_rej = 0;
    bit       e_rdv = 0;
    bit [7:0] e_rdb = 0;

    always #4 clk = ~clk;

    sr_lock_guard #(.ADDR_W(AW)) dut_i (.*);

    function automatic bit [7:0] m_status();
        return {m_lock, 3'b000, m_rng, 2'b00};
    endfunction

    function automatic bit m_allow(input logic [AW-1:0] a);
        case (m_rng)
            2'd0: return 1'b1;
            2'd1: return !(a[AW-1] && a[AW-2]);
            2'd2: return !a[AW-1];
            default: return 1'b0;
        endcase
    endfunction

    // Model update at each rising edge from the inputs held since last edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_lock = 0; m_rng = 0; e_acc = 0; e_rej = 0; e_rdv = 0; e_rdb = 0;
        end else begin
            e_rdv = rd_req;
            if (rd_req) e_rdb = m_status();
            e_acc = 0; e_rej = 0;
            if (wr_done && wr_bits == 4'd8) begin
                if (!wp_n && m_lock) e_rej = 1;
                else begin
                    e_acc = 1;
                    m_lock = wr_data[7];
                    m_rng = wr_data[3:2];
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare every output at the falling edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R1 R2 R3 R4 R5 R7 status", status_byte, m_status());
            chk("R3 R4 R6 accept", wr_accept, e_acc);
            chk("R5 R6 R10 reject", wr_reject, e_rej);
            chk("R8 rd_valid", rd_valid, e_rdv);
            if (e_rdv) chk("R8 rd_byte", rd_byte, e_rdb);
            chk("R1 R9 arr_allow", arr_allow, m_allow(arr_addr));
        end
    end

    task automatic step(input bit d, input int n, input int dat, input bit wp,
                        input bit rd, input int a);
        @(posedge clk);
        #1;
        wr_done = d; wr_bits = 4'(n); wr_data = 8'(dat);
        wp_n = wp; rd_req = rd; arr_addr = AW'(a);
    endtask

    task automatic idle(input bit wp);
        step(0, 0, 0, wp, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, top address allowed.
        step(0, 0, 0, 1, 1, 16'hFFFF);
        // R3, R2: wp high, write all ones.
        step(1, 8, 8'hFF, 1, 0, 0);
        step(0, 0, 0, 1, 1, 16'hFFFF);
        // R5: wp low with lock set, refused.
        step(1, 8, 8'h00, 0, 0, 0);
        idle(0);
        // R6: toggle wp off-strobe, then write with wp high executes.
        idle(1); idle(0);
        step(1, 8, 8'h04, 1, 1, 0);
        // R4: lock clear, wp low, executes.
        step(1, 8, 8'h88, 0, 0, 0);
        // R5 again, with read in same cycle (R8 old value).
        step(1, 8, 8'h08, 0, 1, 0);
        // R7: partial and long counts with wp high.
        step(1, 7, 8'h00, 1, 0, 0);
        step(1, 9, 8'h00, 1, 0, 0);
        step(1, 0, 8'h00, 1, 0, 0);
        idle(1);
        // R9: sweep ranges and addresses.
        for (int r = 0; r < 4; r++) begin
            step(1, 8, r << 2, 1, 0, 0);
            for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 0, k * 16'h2000 + 16'h1FFF);
        end
        // Random mix.
        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 2) == 0, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : 8,
                 $urandom, $urandom_range(0, 1), $urandom_range(0, 1), $urandom);
        idle(1); idle(1);
        @(posedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        finished = 1;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule